// File: doc/BRIEF.md
# SPI Master Serialiser with Forced Chip Select

This block is the shifting core of an SPI master. Software loads two control words, a transfer configuration and an IO-control word, through a small write port. A start pulse then runs a transfer of a set number of words. Words come from a show-ahead transmit FIFO, are shifted out most-significant bit first on `mosi`, and the same number of bits is gathered from `miso` and pushed into a receive FIFO. The word length is programmable from 4 to 32 bits. A clock-edge enable (`half_tick`) from an external divider sets the pace: each strobe moves the serial clock by one half period.

The configuration word picks the word length, the sampling edge, internal loopback, high-speed pad mode and the two error enables. The IO-control word picks the clock idle level, one of four chip-select lines, a separate active level for each line, forced or automatic chip-select assertion, and the tri-state behaviour of the outputs. Two sticky error flags record a transmit FIFO that runs dry inside a transfer and a receive FIFO that is full when a word completes. Both flags clear when the next transfer starts.

Top module: `spi_fcs_master`

## Requirements
- R1: After reset, `sclk` is 0, `busy`, `done`, `tx_pop`, `rx_push`, `hs_active`, `data_oe` and `err_flags` are 0, `cs_oe` is 1, and every `cs_line` bit is 1.
- R2: Config bits 4:0 hold the word length minus one. Field values 0 to 2 give 4-bit words. The low N bits of each transmit word go out on `mosi` MSB first.
- R3: Each received word is the N bits sampled in order, first bit as MSB. It is pushed zero-extended on `rx_data` with a one-cycle `rx_push`.
- R4: When config bit 9 is 1, data is sampled on the leading clock edge and changed on the trailing edge. When it is 0, data changes on the leading edge and is sampled on the trailing edge.
- R5: IO-control bit 10 sets the idle level of `sclk`. `sclk` is at that level between words and between transfers.
- R6: When config bit 8 (loopback) is 1, received bits are taken from the transmitted bit stream and `miso` has no effect.
- R7: `hs_active` follows config bit 10 only while config bit 8 is 0. With loopback set it is 0.
- R8: A transfer moves exactly `word_max` words, where 0 moves none. It ends with a one-cycle `done` in the cycle `busy` falls.
- R9: If the transmit FIFO is empty at a word boundary while words remain, the transfer stalls with `sclk` idle. `err_flags[0]` is set when config bit 12 is 1, and stays 0 otherwise.
- R10: If `rx_full` is high when a word completes, that word is not pushed. `err_flags[1]` is set when config bit 13 is 1. Both flags clear on start.
- R11: IO-control bits 3:2 select line i. Bit 4+i is the active level of line i. Bit 11 forces the selected line active. Bit 8 makes it active only while `busy`. All other lines drive the inverse of their own level bit.
- R12: `data_oe` is 1 while busy or when IO-control bit 0 is 1. `cs_oe` is the inverse of IO-control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_addr | input | 1 | 0 selects configuration, 1 selects IO-control |
| reg_wdata | input | 14 | Control word data |
| start | input | 1 | Starts a transfer when idle |
| word_max | input | CNT_W | Words in the transfer, sampled at start |
| half_tick | input | 1 | One serial clock half period per strobe |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Consumes the head transmit word |
| rx_data | output | 32 | Received word |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_full | input | 1 | Receive FIFO full |
| miso | input | 1 | Serial input |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output |
| cs_line | output | 4 | Chip-select lines |
| data_oe | output | 1 | Output enable for `sclk` and `mosi` |
| cs_oe | output | 1 | Output enable for the chip-select lines |
| hs_active | output | 1 | High-speed pad mode |
| err_flags | output | 2 | Bit 0 under-run, bit 1 over-run |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |

## Verification
A control write takes effect at the clock edge that ends the write cycle, so `hs_active` is correct one cycle later. The chip-select lines and `data_oe` are registered once more and settle two cycles after the write, so the bench samples them two falling edges later. A bench slave model watches `sclk` at falling clock edges while the block is busy and applies the sampling edge that the configuration implies. Whole words are checked only after `done`, which arrives after the last push. Stall and over-run results are sampled a long, fixed interval after start, when the flags are settled.

// File: rtl/spi_fcs_pkg.sv
package spi_fcs_pkg;
  localparam int WORD_W = 32;
  localparam int NUM_CS = 4;
  localparam int REG_W  = 14;
  localparam int NB_W   = $clog2(WORD_W) + 1;

  // configuration word fields
  localparam int CFG_LOOP  = 8;
  localparam int CFG_FIRST = 9;
  localparam int CFG_HS    = 10;
  localparam int CFG_UR_EN = 12;
  localparam int CFG_OR_EN = 13;

  // IO-control word fields
  localparam int IOC_NOTRI = 0;
  localparam int IOC_TRICS = 1;
  localparam int IOC_SEL   = 2;
  localparam int IOC_POL   = 4;
  localparam int IOC_AUTO  = 8;
  localparam int IOC_CPOL  = 10;
  localparam int IOC_FORCE = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_PUSH} xfer_state_t;

  typedef struct packed {
    logic [NB_W-1:0] nbits;
    logic            in_first;
    logic            loop;
    logic            ur_en;
    logic            or_en;
  } xfer_cfg_t;

  function automatic logic [NB_W-1:0] word_bits(input logic [4:0] field);
    if (field < 5'd3) return NB_W'(4);
    return NB_W'(field) + NB_W'(1);
  endfunction
endpackage

// File: rtl/spi_fcs_regs.sv
module spi_fcs_regs
  import spi_fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output xfer_cfg_t         xcfg,
  output logic              hs_active,
  output logic              cpol,
  output logic [1:0]        cs_sel,
  output logic [NUM_CS-1:0] cs_pol,
  output logic              cs_force,
  output logic              cs_auto,
  output logic              no_tri,
  output logic              tri_cs
);
  logic [4:0] len_q;
  logic       loop_q, first_q, ur_q, or_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0; loop_q <= 1'b0; first_q <= 1'b0;
      ur_q <= 1'b0; or_q <= 1'b0; hs_active <= 1'b0;
      cpol <= 1'b0; cs_sel <= '0; cs_pol <= '0;
      cs_force <= 1'b0; cs_auto <= 1'b0; no_tri <= 1'b0; tri_cs <= 1'b0;
    end else if (reg_we && !reg_addr) begin
      len_q     <= reg_wdata[4:0];
      loop_q    <= reg_wdata[CFG_LOOP];
      first_q   <= reg_wdata[CFG_FIRST];
      ur_q      <= reg_wdata[CFG_UR_EN];
      or_q      <= reg_wdata[CFG_OR_EN];
      hs_active <= reg_wdata[CFG_HS] & ~reg_wdata[CFG_LOOP];
    end else if (reg_we && reg_addr) begin
      no_tri   <= reg_wdata[IOC_NOTRI];
      tri_cs   <= reg_wdata[IOC_TRICS];
      cs_sel   <= reg_wdata[IOC_SEL +: 2];
      cs_pol   <= reg_wdata[IOC_POL +: NUM_CS];
      cs_auto  <= reg_wdata[IOC_AUTO];
      cpol     <= reg_wdata[IOC_CPOL];
      cs_force <= reg_wdata[IOC_FORCE];
    end
  end

  assign xcfg.nbits    = word_bits(len_q);
  assign xcfg.in_first = first_q;
  assign xcfg.loop     = loop_q;
  assign xcfg.ur_en    = ur_q;
  assign xcfg.or_en    = or_q;

  AST_HS_NEEDS_NOLOOP: assert property (@(posedge clk) disable iff (rst)
    hs_active |-> !xcfg.loop); // R7
endmodule

// File: rtl/spi_fcs_shift.sv
module spi_fcs_shift
  import spi_fcs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_max,
  input  logic              half_tick,
  input  xfer_cfg_t         xcfg,
  input  logic              cpol,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_push,
  input  logic              rx_full,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [1:0]        err_flags,
  output logic              busy,
  output logic              done
);
  xfer_state_t       state;
  xfer_cfg_t         cur;
  logic              cpol_q, lead;
  logic [NB_W-1:0]   bit_cnt;
  logic [CNT_W-1:0]  words_done, word_max_q;
  logic [WORD_W-1:0] tx_sr, rx_sr, aligned;
  logic [WORD_W:0]   wide_mask;
  logic [NB_W-1:0]   pad;
  logic              in_bit, sample_now;
  logic              unused_mask_top;

  assign pad        = NB_W'(WORD_W) - cur.nbits;
  assign aligned    = tx_data << pad;
  assign wide_mask  = ({{WORD_W{1'b0}}, 1'b1} << cur.nbits) - 1'b1;
  assign unused_mask_top = wide_mask[WORD_W];
  assign in_bit     = cur.loop ? mosi : miso;
  assign sample_now = (lead == cur.in_first);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cur <= '0; cpol_q <= 1'b0; lead <= 1'b1;
      bit_cnt <= '0; words_done <= '0; word_max_q <= '0;
      tx_sr <= '0; rx_sr <= '0; rx_data <= '0;
      sclk <= 1'b0; mosi <= 1'b0; err_flags <= '0;
      tx_pop <= 1'b0; rx_push <= 1'b0; done <= 1'b0;
    end else begin
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          sclk <= cpol;
          if (start) begin
            cur        <= xcfg;
            cpol_q     <= cpol;
            word_max_q <= word_max;
            words_done <= '0;
            err_flags  <= '0;
            state      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (words_done == word_max_q) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (tx_empty) begin
            if (cur.ur_en) err_flags[0] <= 1'b1;
          end else begin
            tx_pop  <= 1'b1;
            bit_cnt <= '0;
            lead    <= 1'b1;
            state   <= ST_SHIFT;
            if (cur.in_first) begin
              mosi  <= aligned[WORD_W-1];
              tx_sr <= aligned << 1;
            end else begin
              tx_sr <= aligned;
            end
          end
        end
        ST_SHIFT: begin
          if (half_tick) begin
            sclk <= ~sclk;
            lead <= ~lead;
            if (sample_now) begin
              rx_sr <= {rx_sr[WORD_W-2:0], in_bit};
            end else begin
              mosi  <= tx_sr[WORD_W-1];
              tx_sr <= tx_sr << 1;
            end
            if (!lead) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == cur.nbits - 1'b1) state <= ST_PUSH;
            end
          end
        end
        ST_PUSH: begin
          words_done <= words_done + 1'b1;
          state      <= ST_LOAD;
          if (rx_full) begin
            if (cur.or_en) err_flags[1] <= 1'b1;
          end else begin
            rx_push <= 1'b1;
            rx_data <= rx_sr & wide_mask[WORD_W-1:0];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> !tx_empty); // R9
  AST_BOUNDARY_CLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |-> (sclk == cpol_q)); // R5
  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !$past(rx_full)); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (words_done <= word_max_q)); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
endmodule

// File: rtl/spi_fcs_csel.sv
module spi_fcs_csel
  import spi_fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [1:0]        cs_sel,
  input  logic [NUM_CS-1:0] cs_pol,
  input  logic              cs_force,
  input  logic              cs_auto,
  input  logic              no_tri,
  input  logic              tri_cs,
  output logic [NUM_CS-1:0] cs_line,
  output logic              data_oe,
  output logic              cs_oe
);
  logic [NUM_CS-1:0] cs_next;
  logic              assert_sel;

  assign assert_sel = cs_force | (cs_auto & busy);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_next[i] = (assert_sel && (cs_sel == 2'(i))) ? cs_pol[i] : ~cs_pol[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_line <= '1;
      data_oe <= 1'b0;
      cs_oe   <= 1'b1;
    end else begin
      cs_line <= cs_next;
      data_oe <= no_tri | busy;
      cs_oe   <= ~tri_cs;
    end
  end

  AST_CS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!$past(cs_force) && !$past(cs_auto)) |-> (cs_line == ~$past(cs_pol))); // R11
endmodule

// File: rtl/spi_fcs_master.sv
module spi_fcs_master
  import spi_fcs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_max,
  input  logic              half_tick,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_push,
  input  logic              rx_full,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_line,
  output logic              data_oe,
  output logic              cs_oe,
  output logic              hs_active,
  output logic [1:0]        err_flags,
  output logic              busy,
  output logic              done
);
  xfer_cfg_t         xcfg;
  logic              cpol, cs_force, cs_auto, no_tri, tri_cs;
  logic [1:0]        cs_sel;
  logic [NUM_CS-1:0] cs_pol;

  spi_fcs_regs u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .xcfg(xcfg), .hs_active(hs_active), .cpol(cpol),
    .cs_sel(cs_sel), .cs_pol(cs_pol), .cs_force(cs_force), .cs_auto(cs_auto),
    .no_tri(no_tri), .tri_cs(tri_cs)
  );

  spi_fcs_shift #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .word_max(word_max),
    .half_tick(half_tick), .xcfg(xcfg), .cpol(cpol),
    .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_push(rx_push), .rx_full(rx_full),
    .miso(miso), .sclk(sclk), .mosi(mosi), .err_flags(err_flags),
    .busy(busy), .done(done)
  );

  spi_fcs_csel u_csel (
    .clk(clk), .rst(rst), .busy(busy), .cs_sel(cs_sel), .cs_pol(cs_pol),
    .cs_force(cs_force), .cs_auto(cs_auto), .no_tri(no_tri), .tri_cs(tri_cs),
    .cs_line(cs_line), .data_oe(data_oe), .cs_oe(cs_oe)
  );
endmodule

// File: tb/spi_fcs_master_test.sv
module spi_fcs_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0, reg_addr = 1'b0;
  logic [13:0] reg_wdata = '0;
  logic start = 1'b0;
  logic [CNT_W-1:0] word_max = '0;
  logic half_tick = 1'b0;
  logic [31:0] tx_data;
  logic tx_empty, tx_pop, rx_push, rx_full = 1'b0, miso = 1'b0;
  logic [31:0] rx_data;
  logic sclk, mosi, data_oe, cs_oe, hs_active, busy, done;
  logic [3:0] cs_line;
  logic [1:0] err_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fcs_master #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .start(start), .word_max(word_max),
    .half_tick(half_tick), .tx_data(tx_data), .tx_empty(tx_empty),
    .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push), .rx_full(rx_full),
    .miso(miso), .sclk(sclk), .mosi(mosi), .cs_line(cs_line),
    .data_oe(data_oe), .cs_oe(cs_oe), .hs_active(hs_active),
    .err_flags(err_flags), .busy(busy), .done(done)
  );

  int checks = 0, errors = 0, cyc = 0;

  // transmit FIFO model (show-ahead)
  logic [31:0] tx_mem [256];
  int tx_rd = 0, tx_avail = 0;
  assign tx_empty = (tx_rd >= tx_avail);
  assign tx_data  = tx_mem[tx_rd % 256];
  always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;

  // bench slave and receive capture
  int m_n = 8, m_first = 1, m_cpol = 0, m_loop = 0, tick_mode = 1;
  logic [31:0] slave_mem [256];
  logic [31:0] mosi_words [256];
  logic [31:0] rx_words [256];
  logic [31:0] cap = '0;
  int wc = 0, idx = 0, rc = 0;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (busy && (sclk != prev_sclk)) begin
      if (((prev_sclk == m_cpol[0]) ? 1 : 0) == m_first) begin
        cap = {cap[30:0], mosi};
        idx = idx + 1;
        if (idx == m_n) begin
          mosi_words[wc % 256] = msk(cap, m_n);
          wc = wc + 1;
          idx = 0;
        end
      end
    end
    prev_sclk = sclk;
    if (m_loop != 0) miso <= 1'($urandom % 2);
    else miso <= slave_mem[wc % 256][m_n - 1 - idx];
    if (rx_push) begin
      rx_words[rc % 256] = rx_data;
      rc = rc + 1;
    end
    half_tick <= (tick_mode != 0) ? 1'b1 : 1'($urandom % 3 == 0);
  end

  function automatic logic [31:0] msk(input logic [31:0] w, input int n);
    if (n >= 32) return w;
    return w & ((32'd1 << n) - 32'd1);
  endfunction

  function automatic int wbits(input int f);
    return (f < 3) ? 4 : f + 1;
  endfunction

  function automatic logic [13:0] mk_cfg(input int lenf, input bit lp, input bit first,
                                         input bit hs, input bit ur, input bit ov);
    logic [13:0] v = '0;
    v[4:0] = 5'(lenf); v[8] = lp; v[9] = first; v[10] = hs; v[12] = ur; v[13] = ov;
    return v;
  endfunction

  function automatic logic [13:0] mk_ioc(input bit notri, input bit tcs, input int sel,
                                         input logic [3:0] pol, input bit aut,
                                         input bit cp, input bit frc);
    logic [13:0] v = '0;
    v[0] = notri; v[1] = tcs; v[3:2] = 2'(sel); v[7:4] = pol; v[8] = aut;
    v[10] = cp; v[11] = frc;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [13:0] v);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
    @(negedge clk);
  endtask

  int base_wc, base_rc, base_tx, cur_nw;

  task automatic setup_xfer(input int nw, input logic [13:0] cfgv,
                            input logic [13:0] iocv, input int avail);
    wr(1'b0, cfgv);
    wr(1'b1, iocv);
    m_n = wbits(int'(cfgv[4:0])); m_first = cfgv[9]; m_cpol = iocv[10];
    m_loop = cfgv[8];
    base_wc = wc; base_rc = rc; base_tx = tx_rd; cur_nw = nw;
    for (int i = 0; i < nw; i++) begin
      tx_mem[(base_tx + i) % 256] = $urandom;
      slave_mem[(base_wc + i) % 256] = $urandom;
    end
    tx_avail = base_tx + avail;
    word_max = CNT_W'(nw);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_xfer(input bit full_exp);
    int lim = 0;
    while (!done && lim < 30000) begin @(negedge clk); lim++; end
    chk(done, "R8 done pulse", 32'(done), 1);
    @(negedge clk);
    chk(!busy && !done, "R8 single done and idle", {busy, done}, 0);
    chk(wc - base_wc == cur_nw, "R8 word count", wc - base_wc, cur_nw);
    chk(rc - base_rc == (full_exp ? 0 : cur_nw), "R10,R3 push count",
        rc - base_rc, full_exp ? 0 : cur_nw);
    for (int i = 0; i < cur_nw; i++) begin
      logic [31:0] etx, erx;
      etx = msk(tx_mem[(base_tx + i) % 256], m_n);
      erx = (m_loop != 0) ? etx : msk(slave_mem[(base_wc + i) % 256], m_n);
      chk(mosi_words[(base_wc + i) % 256] == etx, "R2,R4 mosi word",
          mosi_words[(base_wc + i) % 256], etx);
      if (!full_exp)
        chk(rx_words[(base_rc + i) % 256] == erx, "R3,R6,R4 rx word",
            rx_words[(base_rc + i) % 256], erx);
    end
    chk(sclk == m_cpol[0], "R5 idle clock after transfer", 32'(sclk), m_cpol);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sclk == 0 && busy == 0 && done == 0 && err_flags == 0, "R1 core idle",
        {sclk, busy, done, err_flags}, 0);
    chk(cs_line == 4'hF && cs_oe == 1 && data_oe == 0, "R1 chip select",
        {cs_line, cs_oe, data_oe}, {4'hF, 1'b1, 1'b0});
    chk(hs_active == 0 && tx_pop == 0 && rx_push == 0, "R1 strobes",
        {hs_active, tx_pop, rx_push}, 0);

    // R7 high-speed exclusive with loopback
    wr(1'b0, mk_cfg(7, 0, 1, 1, 0, 0));
    chk(hs_active == 1, "R7 hs on", 32'(hs_active), 1);
    wr(1'b0, mk_cfg(7, 1, 1, 1, 0, 0));
    chk(hs_active == 0, "R7 hs blocked by loopback", 32'(hs_active), 0);

    // R5 idle clock level
    wr(1'b1, mk_ioc(0, 0, 0, 4'h0, 0, 1, 0));
    chk(sclk == 1, "R5 idle high", 32'(sclk), 1);

    // R11 forced chip select and polarity
    wr(1'b1, mk_ioc(0, 0, 2, 4'b0100, 0, 0, 1));
    chk(cs_line == 4'hF, "R11 forced active-high line 2", cs_line, 4'hF);
    wr(1'b1, mk_ioc(0, 0, 2, 4'b0100, 0, 0, 0));
    chk(cs_line == 4'hB, "R11 released line 2", cs_line, 4'hB);
    wr(1'b1, mk_ioc(0, 0, 1, 4'b0000, 0, 0, 1));
    chk(cs_line == 4'hD, "R11 forced active-low line 1", cs_line, 4'hD);

    // R12 tri-state controls
    wr(1'b1, mk_ioc(1, 1, 0, 4'h0, 0, 0, 0));
    chk(data_oe == 1 && cs_oe == 0, "R12 enables", {data_oe, cs_oe}, 2'b10);

    // R8 zero words
    setup_xfer(0, mk_cfg(7, 0, 1, 0, 0, 0), mk_ioc(0, 0, 0, 4'h0, 0, 0, 0), 0);
    finish_xfer(0);

    // R11 automatic select, R12 data_oe during transfer
    tick_mode = 0;
    setup_xfer(2, mk_cfg(15, 0, 0, 0, 0, 0), mk_ioc(0, 0, 3, 4'h0, 1, 0, 0), 2);
    repeat (6) @(negedge clk);
    chk(cs_line == 4'h7, "R11 auto select while busy", cs_line, 4'h7);
    chk(data_oe == 1, "R12 data_oe while busy", 32'(data_oe), 1);
    finish_xfer(0);
    @(negedge clk);
    chk(cs_line == 4'hF, "R11 auto release", cs_line, 4'hF);

    // R2 short field clamps to 4 bits
    tick_mode = 1;
    setup_xfer(3, mk_cfg(1, 0, 1, 0, 0, 0), mk_ioc(0, 0, 0, 4'h0, 0, 0, 0), 3);
    finish_xfer(0);

    // R9 under-run enabled: stall, then resume
    setup_xfer(3, mk_cfg(7, 0, 1, 0, 1, 0), mk_ioc(0, 0, 0, 4'h0, 0, 1, 0), 1);
    repeat (200) @(negedge clk);
    chk(err_flags[0] == 1 && busy == 1, "R9 under-run flag and stall",
        {err_flags, busy}, 3'b011);
    chk(sclk == 1 && wc - base_wc == 1, "R9 clock idle during stall",
        {sclk, 8'(wc - base_wc)}, {1'b1, 8'd1});
    tx_avail = base_tx + 3;
    finish_xfer(0);
    chk(err_flags[0] == 1, "R9 flag sticky", err_flags, 1);

    // R9 under-run disabled; flags clear at start
    setup_xfer(2, mk_cfg(7, 0, 0, 0, 0, 0), mk_ioc(0, 0, 0, 4'h0, 0, 0, 0), 0);
    repeat (100) @(negedge clk);
    chk(err_flags == 0 && busy == 1, "R9 disabled under-run, R10 clear on start",
        {err_flags, busy}, 3'b001);
    tx_avail = base_tx + 2;
    finish_xfer(0);

    // R10 over-run: nothing pushed, flag set
    rx_full = 1'b1;
    setup_xfer(2, mk_cfg(11, 0, 1, 0, 0, 1), mk_ioc(0, 0, 0, 4'h0, 0, 0, 0), 2);
    finish_xfer(1);
    chk(err_flags == 2'b10, "R10 over-run flag", err_flags, 2'b10);
    rx_full = 1'b0;

    // R6 directed loopback with noisy miso, full 32-bit words
    setup_xfer(3, mk_cfg(31, 1, 0, 0, 0, 0), mk_ioc(0, 0, 0, 4'h0, 0, 1, 0), 3);
    finish_xfer(0);

    // random mix of lengths, edges, clock levels and loopback
    for (int t = 0; t < 14; t++) begin
      int lenf, nw;
      lenf = $urandom % 32;
      nw = 1 + $urandom % 5;
      tick_mode = $urandom % 2;
      setup_xfer(nw, mk_cfg(lenf, 1'($urandom % 2), 1'($urandom % 2), 0, 0, 0),
                 mk_ioc(0, 0, 0, 4'h0, 0, 1'($urandom % 2), 0), nw);
      finish_xfer(0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule